// File: doc/BRIEF.md
# Burst Start Delay Sequencer

This block decides when the first low-side pulse of a burst packet may start after the run-enable level goes high. Two waits run side by side: a fixed wake-up interval and a wait for the bias-supply power-good flag. When both are done, a second timed phase waits for a zero-crossing pulse from the auxiliary-winding comparator. The first pulse is released either when the zero crossing arrives or when that phase times out.

The block has three outputs. A one-cycle start strobe tells the pulse generator to begin. A switching-enable level stays high for the rest of the burst. A three-bit phase code shows which wait is in progress. Both intervals are counted in clock cycles derived from a clock-frequency parameter. A parameter selects whether one counter serves both intervals or each interval has its own counter. The two variants behave the same at the ports. When run-enable drops, the sequence is cancelled at once.

Top module: `burst_start_seq`

## Requirements
- R1: While run-enable is low, the start strobe and switching-enable are low in that same cycle. From the next clock edge onward the phase code is 0 (idle). Reset also gives phase 0 and both outputs low.
- R2: On the first clock edge that samples run-enable high while idle, the phase code becomes 1 (wake-up). It stays 1 for exactly WAKE_CYC cycles, which is 275 at the default 125 MHz and 2.2 µs.
- R3: If power-good is low at the end of the wake-up interval, the phase code becomes 2 (power-good wait). It stays 2 until an edge samples power-good high, and becomes 3 (zero-crossing wait) at that edge. If power-good is already high when wake-up ends, the phase goes straight from 1 to 3.
- R4: In phase 3, a high zero-crossing input raises the start strobe and switching-enable in that same cycle.
- R5: If no zero crossing arrives, the start strobe rises in the ZC_CYC-th cycle of phase 3, where ZC_CYC is 275 by default.
- R6: With power-good already high and a zero crossing in the first cycle of phase 3, the strobe comes exactly WAKE_CYC cycles after the edge that first sampled run-enable high.
- R7: Zero-crossing pulses during phase 1 or phase 2 have no effect: the later strobe timing is unchanged.
- R8: If run-enable falls in any phase, the block returns to phase 0 at the next edge. The next start runs the full wake-up interval again.
- R9: After the strobe, the phase code is 4 (switching). Switching-enable stays high until run-enable falls. The strobe is high for exactly one cycle per burst, and zero crossings in phase 4 do not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run-enable level; high starts and holds a burst |
| pgood | input | 1 | Bias-supply power-good flag |
| zc_pulse | input | 1 | Zero-crossing detect from the auxiliary comparator |
| first_strobe | output | 1 | One-cycle start of the first low-side pulse |
| sw_en | output | 1 | Switching-enable level |
| wait_phase | output | 3 | Phase code: 0 idle, 1 wake-up, 2 power-good wait, 3 zero-crossing wait, 4 switching |

## Verification
The phase code is registered, so it changes one edge after the input that causes the change is sampled. The start strobe and switching-enable are combinational from the phase and the inputs, so a zero crossing or a drop of run-enable shows up in the same cycle. The bench changes every input just after a falling edge and checks the outputs 1 ns later. The expected phase is counted in whole cycles from the edge that sampled the change. Both the shared-counter and split-counter builds are checked against the same expected values.

// File: rtl/bss_pkg.sv
package bss_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_WAKE   = 3'd1,
      PH_PGWAIT = 3'd2,
      PH_ZCWAIT = 3'd3,
      PH_SWITCH = 3'd4
   } phase_e;

   // Rounds an interval in ns up to whole clock cycles, never below one.
   function automatic int unsigned ns_to_cycles(longint unsigned hz, longint unsigned ns);
      longint unsigned c;
      c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
      if (c < 1) c = 1;
      return int'(c);
   endfunction

endpackage

// File: rtl/bss_interval_timer.sv
module bss_interval_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [CNT_W-1:0] term,
   output logic             hit
);

   logic [CNT_W-1:0] cnt;

   assign hit = (cnt == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (en && !hit)
         cnt <= cnt + 1'b1;
   end

   // The count never runs past the terminal value while it is counting.
   assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr) |-> (cnt <= term));

endmodule

// File: rtl/bss_phase_fsm.sv
module bss_phase_fsm
   import bss_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   run_en,
   input  logic   pgood,
   input  logic   zc_pulse,
   input  logic   wake_hit,
   input  logic   zc_hit,
   output phase_e phase,
   output logic   enter_zc,
   output logic   strobe,
   output logic   sw_en
);

   phase_e nxt;

   always_comb begin
      nxt = phase;
      if (!run_en) begin
         nxt = PH_IDLE;
      end else begin
         unique case (phase)
            PH_IDLE:   nxt = PH_WAKE;
            PH_WAKE:   if (wake_hit) nxt = pgood ? PH_ZCWAIT : PH_PGWAIT;
            PH_PGWAIT: if (pgood) nxt = PH_ZCWAIT;
            PH_ZCWAIT: if (zc_pulse || zc_hit) nxt = PH_SWITCH;
            PH_SWITCH: nxt = PH_SWITCH;
            default:   nxt = PH_IDLE;
         endcase
      end
   end

   assign enter_zc = (nxt == PH_ZCWAIT) && (phase != PH_ZCWAIT);
   assign strobe   = run_en && (phase == PH_ZCWAIT) && (zc_pulse || zc_hit);
   assign sw_en    = run_en && ((phase == PH_SWITCH) || strobe);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= PH_IDLE;
      else
         phase <= nxt;
   end

   assert_idle_after_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (phase == PH_IDLE));

   assert_wake_before_zc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ZCWAIT && $past(phase) != PH_ZCWAIT) |-> $past(wake_hit));

   assert_pgood_gates_zc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ZCWAIT && $past(phase) != PH_ZCWAIT) |-> $past(pgood));

   assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

   assert_switch_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> (phase == PH_SWITCH));

endmodule

// File: rtl/burst_start_seq.sv
module burst_start_seq
   import bss_pkg::*;
#(
   parameter longint unsigned CLK_HZ       = 125_000_000,
   parameter int unsigned     WAKE_NS      = 2200,
   parameter int unsigned     ZC_NS        = 2200,
   parameter bit              SHARED_TIMER = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_en,
   input  logic       pgood,
   input  logic       zc_pulse,
   output logic       first_strobe,
   output logic       sw_en,
   output logic [2:0] wait_phase
);

   localparam int unsigned WAKE_CYC = ns_to_cycles(CLK_HZ, longint'(WAKE_NS));
   localparam int unsigned ZC_CYC   = ns_to_cycles(CLK_HZ, longint'(ZC_NS));
   localparam int unsigned MAX_CYC  = (WAKE_CYC > ZC_CYC) ? WAKE_CYC : ZC_CYC;
   localparam int          CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
   localparam logic [CNT_W-1:0] WAKE_TERM = CNT_W'(WAKE_CYC - 1);
   localparam logic [CNT_W-1:0] ZC_TERM   = CNT_W'(ZC_CYC - 1);

   if (CLK_HZ == 0) begin : g_bad_clk
      $error("burst_start_seq: CLK_HZ must be nonzero");
   end
   if (WAKE_NS == 0 || ZC_NS == 0) begin : g_bad_interval
      $error("burst_start_seq: intervals must be nonzero");
   end

   phase_e phase;
   logic   enter_zc;
   logic   wake_hit;
   logic   zc_hit;

   bss_phase_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .pgood    (pgood),
      .zc_pulse (zc_pulse),
      .wake_hit (wake_hit),
      .zc_hit   (zc_hit),
      .phase    (phase),
      .enter_zc (enter_zc),
      .strobe   (first_strobe),
      .sw_en    (sw_en)
   );

   if (SHARED_TIMER) begin : g_shared
      logic             hit;
      logic [CNT_W-1:0] term;
      assign term = (phase == PH_ZCWAIT) ? ZC_TERM : WAKE_TERM;

      bss_interval_timer #(.CNT_W(CNT_W)) u_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (enter_zc || phase == PH_IDLE),
         .en    (phase == PH_WAKE || phase == PH_ZCWAIT),
         .term  (term),
         .hit   (hit)
      );
      assign wake_hit = hit;
      assign zc_hit   = hit;
   end else begin : g_split
      bss_interval_timer #(.CNT_W(CNT_W)) u_wake_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (phase == PH_IDLE),
         .en    (phase == PH_WAKE),
         .term  (WAKE_TERM),
         .hit   (wake_hit)
      );
      bss_interval_timer #(.CNT_W(CNT_W)) u_zc_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (phase != PH_ZCWAIT),
         .en    (phase == PH_ZCWAIT),
         .term  (ZC_TERM),
         .hit   (zc_hit)
      );
   end

   assign wait_phase = phase;

   // The wait phases are left only forward or back to idle, never skipped backwards.
   assert_no_backstep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && $past(run_en) && $past(phase) == PH_SWITCH) |-> (phase == PH_SWITCH));

endmodule

// File: tb/burst_start_seq_test.sv
module burst_start_seq_test;

   localparam int WK = (125 * 2200 + 999) / 1000;
   localparam int ZC = (125 * 2200 + 999) / 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_en = 1'b0;
   logic pgood = 1'b0;
   logic zc_pulse = 1'b0;

   logic       stb_a, sw_a, stb_b, sw_b;
   logic [2:0] ph_a, ph_b;

   int checks = 0;
   int errors = 0;
   int stb_count = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   burst_start_seq uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .pgood(pgood), .zc_pulse(zc_pulse),
      .first_strobe(stb_a), .sw_en(sw_a), .wait_phase(ph_a)
   );

   burst_start_seq #(.SHARED_TIMER(1'b0)) uut_split (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .pgood(pgood), .zc_pulse(zc_pulse),
      .first_strobe(stb_b), .sw_en(sw_b), .wait_phase(ph_b)
   );

   always @(posedge clk) if (stb_a === 1'b1) stb_count++;

   task automatic adv(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string tag, logic [2:0] ep, logic es, logic ew);
      checks++;
      if (ph_a !== ep || stb_a !== es || sw_a !== ew ||
          ph_b !== ep || stb_b !== es || sw_b !== ew) begin
         errors++;
         $display("FAIL %s: shared ph=%0d stb=%b sw=%b, split ph=%0d stb=%b sw=%b, expected ph=%0d stb=%b sw=%b",
                  tag, ph_a, stb_a, sw_a, ph_b, stb_b, sw_b, ep, es, ew);
      end
   endtask

   task automatic chk_val(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic t_reset;
      run_en = 1'b1;
      adv(2); #1;
      chk("R1 reset state", 3'd0, 1'b0, 1'b0);
      run_en = 1'b0;
      adv(1);
      rst_n = 1'b1;
      adv(2); #1;
      chk("R1 idle after reset", 3'd0, 1'b0, 1'b0);
   endtask

   task automatic t_fast_start;
      int base;
      pgood = 1'b1;
      run_en = 1'b1;
      base = stb_count;
      adv(1); #1;
      chk("R2 wake first cycle", 3'd1, 1'b0, 1'b0);
      adv(WK - 1); #1;
      chk("R2 wake last cycle", 3'd1, 1'b0, 1'b0);
      adv(1);
      zc_pulse = 1'b1;
      #1;
      chk("R6 minimum delay strobe", 3'd3, 1'b1, 1'b1);
      adv(1);
      zc_pulse = 1'b0;
      #1;
      chk("R9 switching after strobe", 3'd4, 1'b0, 1'b1);
      adv(30); #1;
      chk("R9 switching held", 3'd4, 1'b0, 1'b1);
      chk_val("R9 one strobe per burst", stb_count - base, 1);
      adv(1);
      run_en = 1'b0;
      #1;
      chk("R1 outputs drop with run", 3'd4, 1'b0, 1'b0);
      adv(1); #1;
      chk("R8 idle after drop", 3'd0, 1'b0, 1'b0);
   endtask

   task automatic t_late_pgood;
      pgood = 1'b0;
      run_en = 1'b1;
      adv(1);
      adv(5);
      zc_pulse = 1'b1;
      #1;
      chk("R7 zc ignored in wake", 3'd1, 1'b0, 1'b0);
      adv(1);
      zc_pulse = 1'b0;
      adv(WK - 6); #1;
      chk("R3 power-good wait", 3'd2, 1'b0, 1'b0);
      adv(3);
      zc_pulse = 1'b1;
      #1;
      chk("R7 zc ignored in pg wait", 3'd2, 1'b0, 1'b0);
      adv(1);
      zc_pulse = 1'b0;
      adv(5);
      pgood = 1'b1;
      #1;
      chk("R3 held until sampled", 3'd2, 1'b0, 1'b0);
      adv(1); #1;
      chk("R3 zc wait after pgood", 3'd3, 1'b0, 1'b0);
      adv(ZC - 2); #1;
      chk("R5 before timeout", 3'd3, 1'b0, 1'b0);
      adv(1); #1;
      chk("R5 timeout strobe", 3'd3, 1'b1, 1'b1);
      adv(1); #1;
      chk("R5 switching after timeout", 3'd4, 1'b0, 1'b1);
      run_en = 1'b0;
      adv(2);
   endtask

   task automatic t_abort;
      pgood = 1'b1;
      run_en = 1'b1;
      adv(100);
      run_en = 1'b0;
      #1;
      chk("R1 wake aborted outputs", 3'd1, 1'b0, 1'b0);
      adv(1); #1;
      chk("R8 abort in wake", 3'd0, 1'b0, 1'b0);
      run_en = 1'b1;
      adv(1); #1;
      chk("R8 restart wake", 3'd1, 1'b0, 1'b0);
      adv(WK - 1); #1;
      chk("R8 full wake after restart", 3'd1, 1'b0, 1'b0);
      adv(1); #1;
      chk("R8 zc wait after restart", 3'd3, 1'b0, 1'b0);
      adv(50);
      run_en = 1'b0;
      #1;
      chk("R8 zc wait dropping", 3'd3, 1'b0, 1'b0);
      adv(1); #1;
      chk("R8 abort in zc wait", 3'd0, 1'b0, 1'b0);
      pgood = 1'b0;
      run_en = 1'b1;
      adv(WK + 1); #1;
      chk("R3 pg wait before abort", 3'd2, 1'b0, 1'b0);
      run_en = 1'b0;
      adv(1); #1;
      chk("R8 abort in pg wait", 3'd0, 1'b0, 1'b0);
   endtask

   task automatic t_zc_mid;
      pgood = 1'b1;
      run_en = 1'b1;
      adv(WK + 1);
      adv(40);
      zc_pulse = 1'b1;
      #1;
      chk("R4 zc mid wait", 3'd3, 1'b1, 1'b1);
      adv(1);
      zc_pulse = 1'b0;
      #1;
      chk("R4 switching after zc", 3'd4, 1'b0, 1'b1);
      adv(2);
      zc_pulse = 1'b1;
      #1;
      chk("R9 zc ignored while switching", 3'd4, 1'b0, 1'b1);
      adv(1);
      zc_pulse = 1'b0;
      run_en = 1'b0;
      adv(2); #1;
      chk("R1 idle at end", 3'd0, 1'b0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_fast_start();
      t_late_pgood();
      t_abort();
      t_zc_mid();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule